// File: doc/BRIEF.md
# Interrupt-driven serial console port

This block is a small asynchronous serial port for a debug console. It sits on a simple register bus and offers two word-aligned registers. The data register starts a transmission when written and returns the last received character when read. The divisor register sets the bit rate and can be changed at run time. Characters use 8N1 framing: one start bit, eight data bits and one stop bit, with no parity.

The port has no FIFO and no status register. Software paces itself on two interrupt lines. Each line gives a single-cycle, active-high pulse: one when a character has arrived, and one when a transmitted character has fully left the pin. The receive side keeps only one holding register, so a character that software does not read in time is replaced by the next one.

The bit clock is a tick at 16 times the bit rate. A counter produces one tick every `divisor` system clocks. The reset divisor is computed at elaboration as CLK_HZ / (16 × BAUD).

Top module: `csr_uart`

## Requirements
- R1: After reset, txd is high, both interrupt outputs are low, the data register reads 0x00 and the divisor register reads CLK_HZ/(16*BAUD), which is 27 with the default parameters.
- R2: The divisor register (address bit 2 = 1) holds the value written to its low DIV_W bits. One oversampling tick occurs every `divisor` clocks, and every serial bit lasts 16 ticks.
- R3: A transmitted frame is a low start bit, then the eight data bits LSB first, then a high stop bit. txd is high whenever no frame is in progress.
- R4: tx_irq goes high for exactly one clock when the stop bit of a transmitted frame ends, which is 160 ticks after the frame starts.
- R5: A write to the data register while a frame is being sent is ignored. The current frame goes out unchanged, only one tx_irq is produced, and no second frame follows.
- R6: When a frame with a high stop bit arrives on rxd (LSB first), its byte becomes readable in bits 7:0 of the data register, and rx_irq goes high for exactly one clock.
- R7: A second received character replaces the first in the single holding register, even if the first was never read.
- R8: A frame whose stop bit is sampled low is discarded. No rx_irq is raised and the holding register keeps its previous value.
- R9: A read gives its data on rdata one clock after the select cycle. Address bit 2 alone chooses the register (0 = data, 1 = divisor), and unused upper bits read as zero.
- R10: A low pulse on rxd shorter than half a bit is not taken as a start bit. It produces no rx_irq, and the receiver still accepts the next valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Register access select |
| we | input | 1 | Write enable, qualified by sel |
| addr | input | 14 | Byte address; bit 2 picks the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after a select |
| rx_irq | output | 1 | One-cycle pulse when a character arrives |
| tx_irq | output | 1 | One-cycle pulse when a transmission completes |
| rxd | input | 1 | Serial input, asynchronous, idles high |
| txd | output | 1 | Serial output, idles high |

## Verification
The bench decodes txd at mid-bit positions at two divisor settings, so a design that sends MSB first, stretches a bit or ignores a divisor change will return the wrong byte or raise tx_irq at the wrong time. It writes the data register in the middle of a frame. A transmitter that reloads on that write corrupts the frame or sends a second one. On the receive side it sends two characters without a read between them, a frame with a low stop bit, and a short low glitch. A receiver that keeps the old byte, accepts a broken frame or starts on noise shows the wrong count of rx_irq pulses or the wrong data on read-back. Every interrupt pulse is also checked to last exactly one clock.

// File: rtl/csr_uart.sv
module csr_uart #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int DIV_W  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  logic        we,
  input  logic [13:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rx_irq,
  output logic        tx_irq,
  input  logic        rxd,
  output logic        txd
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(CLK_HZ / (16 * BAUD));

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  logic             wr_data, wr_div, tick;
  logic [DIV_W-1:0] div, dcnt;
  logic             busy;
  logic [9:0]       tsh;
  logic [3:0]       ttc, tbc;
  logic             rmeta, rs, rs_prev;
  rx_st_t           rst_q;
  logic [3:0]       rtc;
  logic [2:0]       rbc;
  logic [7:0]       rsh, rbuf;
  logic             unused_ok;

  assign wr_data   = sel & we & ~addr[2];
  assign wr_div    = sel & we & addr[2];
  assign tick      = ({1'b0, dcnt} + {{DIV_W{1'b0}}, 1'b1}) >= {1'b0, div};
  assign txd       = ~busy | tsh[0];
  assign unused_ok = ^{addr[13:3], addr[1:0], wdata[31:DIV_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      div  <= DIV_RST;
      dcnt <= '0;
    end else if (wr_div) begin
      div  <= wdata[DIV_W-1:0];
      dcnt <= '0;
    end else if (tick) begin
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tsh    <= '1;
      ttc    <= '0;
      tbc    <= '0;
      tx_irq <= 1'b0;
    end else begin
      tx_irq <= 1'b0;
      if (wr_data && !busy) begin
        tsh  <= {1'b1, wdata[7:0], 1'b0};
        busy <= 1'b1;
        ttc  <= '0;
        tbc  <= '0;
      end else if (busy && tick) begin
        ttc <= ttc + 1'b1;
        if (ttc == 4'd15) begin
          tsh <= {1'b1, tsh[9:1]};
          tbc <= tbc + 1'b1;
          if (tbc == 4'd9) begin
            busy   <= 1'b0;
            tx_irq <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {rs_prev, rs, rmeta} <= 3'b111;
      rst_q  <= RX_IDLE;
      rtc    <= '0;
      rbc    <= '0;
      rsh    <= '0;
      rbuf   <= '0;
      rx_irq <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      {rs_prev, rs, rmeta} <= {rs, rmeta, rxd};
      case (rst_q)
        RX_IDLE:
          if (rs_prev && !rs) begin
            rst_q <= RX_START;
            rtc   <= '0;
          end
        RX_START:
          if (tick) begin
            rtc <= rtc + 1'b1;
            if (rtc == 4'd7) begin
              rtc   <= '0;
              rbc   <= '0;
              rst_q <= rs ? RX_IDLE : RX_DATA;
            end
          end
        RX_DATA:
          if (tick) begin
            rtc <= rtc + 1'b1;
            if (rtc == 4'd15) begin
              rsh <= {rs, rsh[7:1]};
              rbc <= rbc + 1'b1;
              if (rbc == 3'd7) rst_q <= RX_STOP;
            end
          end
        default:
          if (tick) begin
            rtc <= rtc + 1'b1;
            if (rtc == 4'd15) begin
              rst_q <= RX_IDLE;
              if (rs) begin
                rbuf   <= rsh;
                rx_irq <= 1'b1;
              end
            end
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (!sel)  rdata <= '0;
    else if (addr[2]) rdata <= {{(32-DIV_W){1'b0}}, div};
    else            rdata <= {24'd0, rbuf};
  end

  a_r1_txd_idle_high: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
  a_r4_tx_irq_one_cycle: assert property (@(posedge clk) disable iff (rst) tx_irq |=> !tx_irq);
  a_r4_tx_irq_at_end: assert property (@(posedge clk) disable iff (rst) tx_irq |-> !busy && $past(busy));
  a_r6_rx_irq_one_cycle: assert property (@(posedge clk) disable iff (rst) rx_irq |=> !rx_irq);
  a_r8_stop_was_high: assert property (@(posedge clk) disable iff (rst) rx_irq |-> $past(rs));
  a_r5_busy_write_keeps_frame: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_data && !tick) |=> $stable(tsh));
endmodule

// File: tb/csr_uart_test.sv
module csr_uart_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_irq, tx_irq;
  logic        rxd = 1'b1;
  logic        txd;

  int total = 0, bad = 0;
  int rx_cnt = 0, tx_cnt = 0;
  bit rx_prev = 0, tx_prev = 0, rx_wide = 0, tx_wide = 0;
  bit finished = 0;

  csr_uart uut (.clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
                .rdata(rdata), .rx_irq(rx_irq), .tx_irq(tx_irq), .rxd(rxd), .txd(txd));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rx_irq) rx_cnt++;
    if (tx_irq) tx_cnt++;
    if (rx_irq && rx_prev) rx_wide = 1;
    if (tx_irq && tx_prev) tx_wide = 1;
    rx_prev = rx_irq;
    tx_prev = tx_irq;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    @(negedge clk);
    sel = 0;
    d = rdata;
  endtask

  task automatic tx_frame(input logic [7:0] b, input bit poke, input int dv);
    logic [9:0] bits = '0;
    int irq_t = -1;
    int base = tx_cnt;
    wr(14'h0, {24'd0, b});
    for (int t = 0; t < 190 * dv; t++) begin
      for (int i = 0; i < 10; i++)
        if (t == (i * 16 + 8) * dv) bits[i] = txd;
      if (tx_irq && irq_t < 0) irq_t = t;
      if (poke && t == 40 * dv) begin
        sel = 1; we = 1; addr = 14'h0; wdata = 32'hC3;
      end else if (poke && t == 40 * dv + 1) begin
        sel = 0; we = 0;
      end
      if (irq_t >= 0 && t > irq_t && !txd) bits[0] = 1'b1;
      @(negedge clk);
    end
    chk("R3 start bit low", {31'd0, bits[0]}, 32'd0);
    chk("R3 data LSB first", {24'd0, bits[8:1]}, {24'd0, b});
    chk("R3 stop bit high", {31'd0, bits[9]}, 32'd1);
    chk("R4 tx_irq timing", {31'd0, (irq_t >= 159 * dv - 1) && (irq_t <= 160 * dv + 1)}, 32'd1);
    chk(poke ? "R5 single tx_irq" : "R4 single tx_irq", tx_cnt - base, 1);
    chk("R3 txd idle high", {31'd0, txd}, 32'd1);
  endtask

  task automatic rx_send(input logic [7:0] b, input bit stop_hi, input int dv);
    logic [9:0] f = {stop_hi, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxd = f[i];
      repeat (16 * dv - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (32 * dv) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 txd high", {31'd0, txd}, 32'd1);
    chk("R1 irqs low", {30'd0, rx_irq, tx_irq}, 32'd0);
    rd(14'h0, d);
    chk("R1 data reset", d, 32'h0);
    rd(14'h4, d);
    chk("R1 divisor reset", d, 32'd27);
  endtask

  task automatic t_divisor;
    logic [31:0] d;
    wr(14'h4, 32'h4);
    rd(14'h4, d);
    chk("R2 divisor readback", d, 32'd4);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    int base = rx_cnt;
    rx_send(8'h5A, 1, 4);
    chk("R6 one rx_irq", rx_cnt - base, 1);
    rd(14'h0, d);
    chk("R6 received byte", d, 32'h5A);
  endtask

  task automatic t_overwrite;
    logic [31:0] d;
    int base = rx_cnt;
    rx_send(8'h11, 1, 4);
    rx_send(8'h22, 1, 4);
    chk("R7 two rx_irq", rx_cnt - base, 2);
    rd(14'h0, d);
    chk("R7 newest byte kept", d, 32'h22);
  endtask

  task automatic t_bad_stop;
    logic [31:0] d;
    int base = rx_cnt;
    rx_send(8'h77, 0, 4);
    chk("R8 no rx_irq", rx_cnt - base, 0);
    rd(14'h0, d);
    chk("R8 data unchanged", d, 32'h22);
  endtask

  task automatic t_glitch;
    logic [31:0] d;
    int base = rx_cnt;
    @(negedge clk);
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (320) @(negedge clk);
    chk("R10 glitch ignored", rx_cnt - base, 0);
    rx_send(8'hC6, 1, 4);
    chk("R10 recovery irq", rx_cnt - base, 1);
    rd(14'h0, d);
    chk("R10 recovery byte", d, 32'hC6);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    rd(14'h10, d);
    chk("R9 data alias addr 0x10", d, 32'hC6);
    rd(14'h0C, d);
    chk("R9 divisor alias addr 0x0C", d, 32'd4);
  endtask

  task automatic t_busy_write;
    bit low_seen = 0;
    tx_frame(8'h3C, 1, 4);
    for (int t = 0; t < 40 * 4; t++) begin
      if (!txd) low_seen = 1;
      @(negedge clk);
    end
    chk("R5 no second frame", {31'd0, low_seen}, 32'd0);
  endtask

  task automatic t_new_rate;
    wr(14'h4, 32'h2);
    tx_frame(8'h81, 0, 2);
    wr(14'h4, 32'h4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_divisor();
    tx_frame(8'hA5, 0, 4);
    t_busy_write();
    t_new_rate();
    t_rx_basic();
    t_overwrite();
    t_bad_stop();
    t_glitch();
    t_decode();
    chk("R4 tx_irq one cycle wide", {31'd0, tx_wide}, 32'd0);
    chk("R6 rx_irq one cycle wide", {31'd0, rx_wide}, 32'd0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule